// File: doc/BRIEF.md
# Bus Timeout and Fault Capture Unit

This unit sits beside the physical-address side of a memory management front end and classifies every CPU access as it is issued. It looks at the page-entry attributes that arrive with the access (valid, writable, system) and at the physical address and address space. An access can go through an invalid entry, break a write or privilege rule, or land in a hole of main-memory space where no memory answers. When any of these happens, the unit records a cause word and the faulting address in two capture registers and pulses a fault line to the CPU.

A read that lands in the hole completes with all-ones data, so the CPU never waits on it. A write that faults is held back from storage: the write enable passed on to memory is suppressed in the same cycle. The CPU can also load either capture register directly, for example to clear the cause word after handling a fault.

Top module: `bus_fault_capture`

## Requirements
- R1: After reset the cause word and the fault address are zero, and faultPulse and rdValid are low.
- R2: A valid read whose page entry is valid and permitted, in space 0, at an address from 0x04000000 to 0x0FFFFFFF inclusive, sets the cause word to exactly 0x00000020 on the next cycle, presents rdData = all ones with rdValid high for that one cycle, and loads the fault address.
- R3: A timed-out write (same address and space rule as R2) sets the cause word to exactly 0x00008020 and loads the fault address.
- R4: A read through an invalid page entry (pteValid=0) sets cause bit 7 and clears cause bit 15, keeping every other cause bit.
- R5: A write through an invalid page entry sets cause bits 15 and 7, keeping every other cause bit.
- R6: A write to a valid entry with pteWrite=0, or with pteSystem=1 while reqSuper=0, sets cause bits 15 and 6, keeping the other bits; reads to such pages do not fault.
- R7: Only one class applies per access, in priority order invalid entry, then protection, then timeout.
- R8: Every faulting access loads the fault address with reqAddr; a non-faulting access changes neither capture register.
- R9: faultPulse is high for exactly the one cycle after each faulting access and low after every non-faulting cycle; rdValid is low except after a timed-out read.
- R10: memWrEn follows reqValid and reqWrite in the same cycle and is held low for any write that faults.
- R11: With regWrEn high, regWrSel=0 loads the cause word and regWrSel=1 loads the fault address from regWrData on the next cycle; a fault in the same cycle takes precedence over both.
- R12: Accesses in space 1, or in space 0 below 0x04000000 or above 0x0FFFFFFF, never time out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access issued this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqSpace | input | 1 | 0 = main-memory space, 1 = device space |
| reqAddr | input | ADDR_W | Physical byte address of the access |
| reqSuper | input | 1 | Access made in supervisor mode |
| pteValid | input | 1 | Page entry is valid |
| pteWrite | input | 1 | Page entry permits writes |
| pteSystem | input | 1 | Page entry is supervisor-only |
| regWrEn | input | 1 | CPU write to a capture register |
| regWrSel | input | 1 | 0 selects the cause word, 1 the fault address |
| regWrData | input | DATA_W | Data for a CPU capture-register write |
| memWrEn | output | 1 | Write enable passed to storage |
| rdData | output | DATA_W | Data returned for a timed-out read |
| rdValid | output | 1 | rdData is valid this cycle |
| causeReg | output | DATA_W | Captured cause word |
| faultAddr | output | ADDR_W | Captured faulting address |
| faultPulse | output | 1 | Memory-access-error pulse to the CPU |

## Verification
memWrEn is combinational and is due in the cycle the access is presented, so the bench samples it shortly after driving the inputs on a falling edge. The cause word, fault address, rdData, rdValid and faultPulse each pass through one register and are due one cycle later; the bench drives on one falling edge and samples on the next, after the single rising edge between them. One more idle cycle then confirms that faultPulse and rdValid have dropped. The sweep covers every combination of direction, space, the three entry bits, privilege and five address points around both range edges.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

  // Cause-word bit positions
  localparam int CAUSE_WRITE_BIT   = 15;
  localparam int CAUSE_INVALID_BIT = 7;
  localparam int CAUSE_PROTECT_BIT = 6;
  localparam int CAUSE_TIMEOUT_BIT = 5;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PROTECT = 2'd2,
    FLT_TIMEOUT = 2'd3
  } faultKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       raiseFault;
    faultKind_t kind;
    logic       isWrite;
    logic       cpuCause;
    logic       cpuAddr;
  } bfcStrobes_t;

endpackage

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
  import bfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] HOLE_LO = 32'h0400_0000,
  parameter logic [ADDR_W-1:0] HOLE_HI = 32'h0FFF_FFFF
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSpace,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSuper,
  input  logic              pteValid,
  input  logic              pteWrite,
  input  logic              pteSystem,
  input  logic              regWrEn,
  input  logic              regWrSel,
  output bfcStrobes_t       strobes,
  output logic              memWrEn
);

  logic inHole;
  logic protViolation;
  faultKind_t kind;

  always_comb begin
    inHole = (reqSpace == 1'b0) && (reqAddr >= HOLE_LO) && (reqAddr <= HOLE_HI);
    protViolation = reqWrite && (!pteWrite || (pteSystem && !reqSuper));
  end

  // Priority: invalid entry, then protection, then timeout
  always_comb begin
    kind = FLT_NONE;
    if (reqValid) begin
      if (!pteValid)          kind = FLT_INVALID;
      else if (protViolation) kind = FLT_PROTECT;
      else if (inHole)        kind = FLT_TIMEOUT;
    end
  end

  always_comb begin
    strobes.raiseFault = (kind != FLT_NONE);
    strobes.kind       = kind;
    strobes.isWrite    = reqWrite;
    strobes.cpuCause   = regWrEn && !regWrSel && (kind == FLT_NONE);
    strobes.cpuAddr    = regWrEn &&  regWrSel && (kind == FLT_NONE);
    memWrEn            = reqValid && reqWrite && (kind == FLT_NONE);
  end

endmodule

// File: rtl/bfc_datapath.sv
module bfc_datapath
  import bfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfcStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] causeReg,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] nextCause;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] cpuAddrWord;

  always_comb begin
    cpuAddrWord = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < DATA_W) cpuAddrWord[i] = regWrData[i];
    end
  end

  always_comb begin
    nextCause = causeReg;
    if (strobes.raiseFault) begin
      unique case (strobes.kind)
        FLT_TIMEOUT: begin
          nextCause = '0;
          nextCause[CAUSE_TIMEOUT_BIT] = 1'b1;
          nextCause[CAUSE_WRITE_BIT]   = strobes.isWrite;
        end
        FLT_INVALID: begin
          nextCause[CAUSE_INVALID_BIT] = 1'b1;
          nextCause[CAUSE_WRITE_BIT]   = strobes.isWrite;
        end
        FLT_PROTECT: begin
          nextCause[CAUSE_PROTECT_BIT] = 1'b1;
          nextCause[CAUSE_WRITE_BIT]   = 1'b1;
        end
        default: nextCause = causeReg;
      endcase
    end else if (strobes.cpuCause) begin
      nextCause = regWrData;
    end
  end

  always_comb begin
    nextAddr = faultAddr;
    if (strobes.raiseFault)   nextAddr = reqAddr;
    else if (strobes.cpuAddr) nextAddr = cpuAddrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg   <= '0;
      faultAddr  <= '0;
      faultPulse <= 1'b0;
      rdValid    <= 1'b0;
      rdData     <= '0;
    end else begin
      causeReg   <= nextCause;
      faultAddr  <= nextAddr;
      faultPulse <= strobes.raiseFault;
      rdValid    <= strobes.raiseFault && (strobes.kind == FLT_TIMEOUT) && !strobes.isWrite;
      rdData     <= (strobes.raiseFault && (strobes.kind == FLT_TIMEOUT)) ? ALL_ONES : '0;
    end
  end

endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] HOLE_LO = 32'h0400_0000,
  parameter logic [ADDR_W-1:0] HOLE_HI = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSpace,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSuper,
  input  logic              pteValid,
  input  logic              pteWrite,
  input  logic              pteSystem,
  input  logic              regWrEn,
  input  logic              regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic              memWrEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] causeReg,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultPulse
);

  bfcStrobes_t strobes;

  bfc_ctrl #(
    .ADDR_W (ADDR_W),
    .HOLE_LO(HOLE_LO),
    .HOLE_HI(HOLE_HI)
  ) i_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSpace (reqSpace),
    .reqAddr  (reqAddr),
    .reqSuper (reqSuper),
    .pteValid (pteValid),
    .pteWrite (pteWrite),
    .pteSystem(pteSystem),
    .regWrEn  (regWrEn),
    .regWrSel (regWrSel),
    .strobes  (strobes),
    .memWrEn  (memWrEn)
  );

  bfc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .regWrData (regWrData),
    .causeReg  (causeReg),
    .faultAddr (faultAddr),
    .faultPulse(faultPulse),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] HOLE_LO = 32'h0400_0000,
  parameter logic [ADDR_W-1:0] HOLE_HI = 32'h0FFF_FFFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqSpace,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqSuper,
  input logic              pteValid,
  input logic              pteWrite,
  input logic              pteSystem,
  input logic              regWrEn,
  input logic              memWrEn,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic [DATA_W-1:0] causeReg,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              faultPulse
);

  logic hole;
  logic permitted;
  assign hole      = !reqSpace && (reqAddr >= HOLE_LO) && (reqAddr <= HOLE_HI);
  assign permitted = pteValid && (!reqWrite || (pteWrite && (!pteSystem || reqSuper)));

  assert_timeout_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && permitted && hole) |=>
      (causeReg == DATA_W'(32'h20)) && rdValid && (rdData == {DATA_W{1'b1}}) && faultPulse);

  assert_timeout_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && permitted && hole) |=> (causeReg == DATA_W'(32'h8020)) && faultPulse);

  assert_invalid_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !pteValid) |=> causeReg[15] && causeReg[7]);

  assert_fault_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(permitted && !hole)) |=> (faultAddr == $past(reqAddr)));

  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && !regWrEn) |=> ($stable(causeReg) && $stable(faultAddr)));

  assert_no_spurious_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || (permitted && !hole)) |=> !faultPulse && !rdValid);

  assert_write_blocked_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (reqValid && reqWrite && permitted && !hole));

endmodule

bind bus_fault_capture bfc_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .HOLE_LO(HOLE_LO),
  .HOLE_HI(HOLE_HI)
) i_bfcChecker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqSpace  (reqSpace),
  .reqAddr   (reqAddr),
  .reqSuper  (reqSuper),
  .pteValid  (pteValid),
  .pteWrite  (pteWrite),
  .pteSystem (pteSystem),
  .regWrEn   (regWrEn),
  .memWrEn   (memWrEn),
  .rdData    (rdData),
  .rdValid   (rdValid),
  .causeReg  (causeReg),
  .faultAddr (faultAddr),
  .faultPulse(faultPulse)
);

// File: tb/test_bus_fault_capture.sv
`timescale 1ns/1ps
module test_bus_fault_capture;

  localparam logic [31:0] LO = 32'h0400_0000;
  localparam logic [31:0] HI = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSpace = 1'b0, reqSuper = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        pteValid = 1'b0, pteWrite = 1'b0, pteSystem = 1'b0;
  logic        regWrEn = 1'b0, regWrSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic        memWrEn, rdValid, faultPulse;
  logic [31:0] rdData, causeReg, faultAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_fault_capture i_bus_fault_capture (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSpace(reqSpace), .reqAddr(reqAddr), .reqSuper(reqSuper),
    .pteValid(pteValid), .pteWrite(pteWrite), .pteSystem(pteSystem),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .memWrEn(memWrEn), .rdData(rdData), .rdValid(rdValid),
    .causeReg(causeReg), .faultAddr(faultAddr), .faultPulse(faultPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    reqValid = 0; reqWrite = 0; reqSpace = 0; reqAddr = '0; reqSuper = 0;
    pteValid = 0; pteWrite = 0; pteSystem = 0; regWrEn = 0; regWrSel = 0; regWrData = '0;
  endtask

  task automatic cpuLoad(input logic sel, input logic [31:0] val);
    @(negedge clk);
    idleInputs();
    regWrEn = 1; regWrSel = sel; regWrData = val;
  endtask

  function automatic logic [31:0] addrFor(input int region, input int idx);
    case (region)
      0: return LO - 32'd4;
      1: return LO;
      2: return LO + 32'(idx) * 32'h0001_0004;
      3: return HI;
      default: return HI + 32'd1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int idx;
    idleInputs();
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 cause", causeReg, 32'h0);
    chk("R1 addr", faultAddr, 32'h0);
    chk("R1 pulse", {31'b0, faultPulse}, 32'h0);
    chk("R1 rdValid", {31'b0, rdValid}, 32'h0);
    rstN = 1;

    idx = 0;
    for (int wr = 0; wr < 2; wr++)
    for (int sp = 0; sp < 2; sp++)
    for (int pv = 0; pv < 2; pv++)
    for (int pw = 0; pw < 2; pw++)
    for (int ps = 0; ps < 2; ps++)
    for (int su = 0; su < 2; su++)
    for (int rg = 0; rg < 5; rg++) begin
      logic [31:0] pat, preAddr, a, expCause, expAddr;
      logic inv, prot, tmo, flt;
      pat     = {idx[15:0], (idx[0] ? 16'h8001 : 16'h0101)};
      preAddr = 32'hA5A5_0000 | 32'(idx);
      a       = addrFor(rg, idx);

      cpuLoad(1'b0, pat);
      cpuLoad(1'b1, preAddr);
      @(negedge clk);
      idleInputs();
      // R11: CPU loads of both capture registers
      chk("R11 cause load", causeReg, pat);

      reqValid = 1; reqWrite = wr[0]; reqSpace = sp[0]; reqAddr = a;
      pteValid = pv[0]; pteWrite = pw[0]; pteSystem = ps[0]; reqSuper = su[0];

      inv  = !pv[0];
      prot = pv[0] && wr[0] && (!pw[0] || (ps[0] && !su[0]));
      tmo  = pv[0] && !prot && !sp[0] && (a >= LO) && (a <= HI);
      flt  = inv || prot || tmo;
      if (inv)       expCause = wr[0] ? (pat | 32'h8080) : ((pat | 32'h80) & ~32'h8000);
      else if (prot) expCause = pat | 32'h8040;
      else if (tmo)  expCause = wr[0] ? 32'h8020 : 32'h20;
      else           expCause = pat;
      expAddr = flt ? a : preAddr;

      #1;
      // R10: write enable gated in the same cycle
      chk("R10 memWrEn", {31'b0, memWrEn}, {31'b0, wr[0] && !flt});
      chk("R11 addr load", faultAddr, preAddr);
      @(negedge clk);
      idleInputs();
      // R2-R7, R12: cause word per class and priority
      if (inv)       chk(wr[0] ? "R5 invalid write" : "R4 invalid read", causeReg, expCause);
      else if (prot) chk("R6 protect", causeReg, expCause);
      else if (tmo)  chk(wr[0] ? "R3 timeout write" : "R2 timeout read", causeReg, expCause);
      else           chk("R12 no timeout", causeReg, expCause);
      if (pv[0] == 0 && sp[0] == 0 && rg == 2) chk("R7 priority", causeReg, expCause);
      chk("R8 fault addr", faultAddr, expAddr);
      chk("R9 pulse", {31'b0, faultPulse}, {31'b0, flt});
      chk("R2 rdValid", {31'b0, rdValid}, {31'b0, tmo && !wr[0]});
      if (tmo && !wr[0]) chk("R2 rdData", rdData, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R9 pulse drop", {31'b0, faultPulse}, 32'h0);
      chk("R9 rdValid drop", {31'b0, rdValid}, 32'h0);
      idx++;
    end

    // R11: fault in the same cycle as a CPU write wins
    cpuLoad(1'b0, 32'h0000_0001);
    @(negedge clk);
    idleInputs();
    reqValid = 1; reqWrite = 1; reqAddr = 32'h0500_0010; pteValid = 1; pteWrite = 1; reqSuper = 1;
    regWrEn = 1; regWrSel = 0; regWrData = 32'h1234_5678;
    @(negedge clk);
    idleInputs();
    chk("R11 fault beats cpu cause", causeReg, 32'h8020);
    reqValid = 1; reqAddr = 32'h0000_0040; pteValid = 0;
    regWrEn = 1; regWrSel = 1; regWrData = 32'hDEAD_BEEF;
    @(negedge clk);
    idleInputs();
    chk("R11 fault beats cpu addr", faultAddr, 32'h0000_0040);
    chk("R4 after timeout", causeReg, 32'h0000_00A0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule